// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control core of a stepped digital potentiometer with a resolution of `CODE_W` bits (5, 6 or 7). It takes three slow interface pins: an active-low select, an interface clock and a direction level. It resynchronises them to a fast system clock, which runs at least four times the interface rate. On each falling edge of the interface clock it moves a wiper position register by one step. Past the normal code range there are two extra end steps, bottom scale and top scale, and the counter saturates at both of them.

The block also decodes a shutdown command from the order of the edges on the direction and clock pins. The shutdown flag tells the resistor array to open terminal A and to tie the wiper to terminal B. The next operation clears the flag and leaves the held position as it was. A lock input from the nonvolatile store sequencer freezes every step and command while it is high. The resistor array, the analog behaviour and the nonvolatile storage sit outside this block.

Top module: `updn_wiper_ctrl`

## Requirements
- R1: After reset, code_o is midscale 2^(CODE_W-1), and bot_o, top_o and shdn_o are all 0.
- R2: With cs_ni low, each falling edge of sclk_i moves the position one step: up when dir_i is 1 and down when dir_i is 0. A rising edge of sclk_i has no effect.
- R3: A down step from code 0 enters bottom scale (bot_o=1, code_o=0). An up step from code 2^CODE_W-1 enters top scale (top_o=1, code_o all ones).
- R4: A down step in bottom scale and an up step in top scale leave the state unchanged, so the counter never wraps. An up step from bottom scale gives code 0 with bot_o=0. A down step from top scale gives code 2^CODE_W-1 with top_o=0.
- R5: A rising edge of dir_i while sclk_i is high and cs_ni is low arms a shutdown. The next falling edge of sclk_i then sets shdn_o=1 and moves nothing.
- R6: While shdn_o=1, the next step edge clears shdn_o and leaves code_o, bot_o and top_o as they were.
- R7: If dir_i falls again before sclk_i falls, the armed shutdown is dropped. That clock fall is then an ordinary step in the direction given by dir_i.
- R8: While lock_i is 1, clock edges and commands are ignored. No step is made and no shutdown is armed or executed.
- R9: While cs_ni is high, clock edges are ignored. A rise of cs_ni cancels an armed shutdown, and the next clock fall with cs_ni low is an ordinary step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Interface select, active low, asynchronous |
| sclk_i | input | 1 | Interface step clock, acts on its falling edge, asynchronous |
| dir_i | input | 1 | Direction level (1 up, 0 down) and command line, asynchronous |
| lock_i | input | 1 | Store sequencer busy, system clock domain |
| code_o | output | CODE_W | Current wiper code |
| bot_o | output | 1 | Position is in the bottom-scale step |
| top_o | output | 1 | Position is in the top-scale step |
| shdn_o | output | 1 | Shutdown: A open, W tied to B |

## Verification
The hardest situations to reach are the command orderings, where the meaning of one clock fall depends on what dir_i and cs_ni did during the preceding high phase of sclk_i. The stimulus tasks build each ordering phase by phase, holding every level for several system clocks: a plain rise, a rise followed by a fall, a rise cancelled by a select pulse, and a rise under lock. Each run then ends with the same clock fall, and the bench checks whether that fall stepped, shut down or did nothing. Both end steps are reached by long runs of steps in one direction followed by extra steps past the end.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    POS_BOT  = 2'd0,
    POS_CODE = 2'd1,
    POS_TOP  = 2'd2
  } pos_kind_e;
endpackage

// File: rtl/updn_pin_sync.sv
module updn_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/updn_cmd_dec.sv
module updn_cmd_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_s_i,
  input  logic sclk_s_i,
  input  logic dir_s_i,
  input  logic lock_i,
  output logic step_o,
  output logic up_o,
  output logic shdn_cmd_o
);
  logic sclk_q, dir_q, armed_q, armed_d;
  logic sclk_fall, dir_rise, dir_fall, active;

  assign sclk_fall = sclk_q & ~sclk_s_i;
  assign dir_rise  = ~dir_q & dir_s_i;
  assign dir_fall  = dir_q & ~dir_s_i;
  assign active    = ~cs_n_s_i & ~lock_i;

  always_comb begin
    armed_d = armed_q;
    if (!active)                  armed_d = 1'b0;  // select high or locked
    else if (sclk_fall)           armed_d = 1'b0;  // consumed
    else if (sclk_s_i && dir_rise) armed_d = 1'b1;
    else if (sclk_s_i && dir_fall) armed_d = 1'b0;  // pulse, not shutdown
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      dir_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_s_i;
      dir_q   <= dir_s_i;
      armed_q <= armed_d;
    end
  end

  assign shdn_cmd_o = active & sclk_fall & armed_q;
  assign step_o     = active & sclk_fall & ~armed_q;
  assign up_o       = dir_s_i;

  a_r9_cs_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !armed_q);
  a_r5_arm_from_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> ($past(sclk_s_i) && $past(dir_s_i)));
endmodule

// File: rtl/updn_pos_reg.sv
module updn_pos_reg
  import updn_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              up_i,
  input  logic              shdn_cmd_i,
  input  logic              lock_i,
  output logic [CODE_W-1:0] code_o,
  output logic              bot_o,
  output logic              top_o,
  output logic              shdn_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

  pos_kind_e         kind_q, kind_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              shdn_q, shdn_d;

  always_comb begin
    kind_d = kind_q;
    code_d = code_q;
    shdn_d = shdn_q;
    if (shdn_cmd_i) begin
      shdn_d = 1'b1;
    end else if (step_i && shdn_q) begin
      shdn_d = 1'b0;  // wake in place
    end else if (step_i) begin
      if (up_i) begin
        unique case (kind_q)
          POS_BOT:  begin kind_d = POS_CODE; code_d = '0; end
          POS_CODE: if (code_q == CODE_MAX) kind_d = POS_TOP;
                    else code_d = code_q + 1'b1;
          default:  ;
        endcase
      end else begin
        unique case (kind_q)
          POS_TOP:  begin kind_d = POS_CODE; code_d = CODE_MAX; end
          POS_CODE: if (code_q == '0) kind_d = POS_BOT;
                    else code_d = code_q - 1'b1;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= POS_CODE;
      code_q <= CODE_MID;
      shdn_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      code_q <= code_d;
      shdn_q <= shdn_d;
    end
  end

  assign code_o = code_q;
  assign bot_o  = (kind_q == POS_BOT);
  assign top_o  = (kind_q == POS_TOP);
  assign shdn_o = shdn_q;

  a_r3_top_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(top_o) |-> ($past(code_o) == CODE_MAX));
  a_r3_bot_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bot_o) |-> ($past(code_o) == '0));
  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |->
      ((code_o == $past(code_o) + 1'b1) || (code_o == $past(code_o) - 1'b1)));
  a_r5_shdn_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shdn_o) |-> ($stable(code_o) && $stable(bot_o) && $stable(top_o)));
  a_r6_wake_in_place: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shdn_o) |-> ($stable(code_o) && $stable(bot_o) && $stable(top_o)));
  a_r8_lock_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(code_o) && $stable(shdn_o) && $stable(bot_o) && $stable(top_o)));
endmodule

// File: rtl/updn_wiper_ctrl.sv
module updn_wiper_ctrl #(
  parameter int CODE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              dir_i,
  input  logic              lock_i,
  output logic [CODE_W-1:0] code_o,
  output logic              bot_o,
  output logic              top_o,
  output logic              shdn_o
);
  localparam int         NPINS   = 3;
  localparam logic [2:0] PIN_RST = 3'b100;  // {cs_n, sclk, dir}

  logic [NPINS-1:0] pin_raw, pin_s;
  logic step, up, shdn_cmd;

  assign pin_raw = {cs_ni, sclk_i, dir_i};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    updn_pin_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_RST[g])
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[g]),
      .q_o   (pin_s[g])
    );
  end

  updn_cmd_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_s_i  (pin_s[2]),
    .sclk_s_i  (pin_s[1]),
    .dir_s_i   (pin_s[0]),
    .lock_i    (lock_i),
    .step_o    (step),
    .up_o      (up),
    .shdn_cmd_o(shdn_cmd)
  );

  updn_pos_reg #(.CODE_W(CODE_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .up_i      (up),
    .shdn_cmd_i(shdn_cmd),
    .lock_i    (lock_i),
    .code_o    (code_o),
    .bot_o     (bot_o),
    .top_o     (top_o),
    .shdn_o    (shdn_o)
  );
endmodule

// File: tb/sim_updn_wiper_ctrl.sv
module sim_updn_wiper_ctrl;
  localparam int CW = 5;
  localparam int PH = 4;  // system clocks per interface phase

  // ops: 0 up, 1 down, 2 shutdown, 3 cs-cancelled, 4 locked up,
  //      5 locked shutdown, 6 up with cs high, 7 dir pulse then down
  // expected = {shdn, bot, top, code[4:0]}
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 8'h11}, {3'd1, 8'h10}, {3'd1, 8'h0F}, {3'd2, 8'h8F},
    {3'd0, 8'h0F}, {3'd0, 8'h10}, {3'd3, 8'h11}, {3'd4, 8'h11},
    {3'd5, 8'h11}, {3'd6, 8'h11}, {3'd7, 8'h10}, {3'd2, 8'h90},
    {3'd1, 8'h10}
  };
  localparam string VREQ [NV] = '{"R2", "R2", "R2", "R5", "R6", "R6", "R9",
                                  "R8", "R8", "R9", "R7", "R5", "R6"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, dir = 1'b0, lock = 1'b0;
  logic [CW-1:0] code;
  logic bot, top, shdn;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  updn_wiper_ctrl #(.CODE_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .dir_i(dir),
    .lock_i(lock), .code_o(code), .bot_o(bot), .top_o(top), .shdn_o(shdn)
  );

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {shdn, bot, top, code};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse();
    sclk = 1'b1; wt(PH);
    sclk = 1'b0; wt(PH);
  endtask

  task automatic step(input logic d);
    dir = d; wt(PH);
    pulse();
  endtask

  task automatic shdn_seq();
    dir = 1'b0; wt(PH);
    sclk = 1'b1; wt(PH);
    dir = 1'b1; wt(PH);
    sclk = 1'b0; wt(PH);
  endtask

  task automatic do_op(input logic [2:0] op);
    case (op)
      3'd0: step(1'b1);
      3'd1: step(1'b0);
      3'd2: shdn_seq();
      3'd3: begin
        dir = 1'b0; wt(PH); sclk = 1'b1; wt(PH);
        dir = 1'b1; wt(PH);
        cs_n = 1'b1; wt(PH); cs_n = 1'b0; wt(PH);
        sclk = 1'b0; wt(PH);
      end
      3'd4: begin lock = 1'b1; wt(PH); step(1'b1); lock = 1'b0; end
      3'd5: begin lock = 1'b1; wt(PH); shdn_seq(); lock = 1'b0; end
      3'd6: begin cs_n = 1'b1; wt(PH); step(1'b1); cs_n = 1'b0; end
      default: begin
        dir = 1'b0; wt(PH); sclk = 1'b1; wt(PH);
        dir = 1'b1; wt(PH); dir = 1'b0; wt(PH);
        sclk = 1'b0; wt(PH);
      end
    endcase
    wt(PH);
  endtask

  initial begin
    wt(3);
    chk("R1", 8'h10);  // midscale while in reset
    rst_n = 1'b1; wt(2);
    cs_n = 1'b0; wt(PH);
    chk("R1", 8'h10);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][10:8]);
      chk(VREQ[i], VEC[i][7:0]);
    end

    // R2: rising clock edge alone does nothing
    dir = 1'b1; wt(PH);
    sclk = 1'b1; wt(PH + 2);
    chk("R2", 8'h10);
    sclk = 1'b0; wt(PH + 2);
    chk("R2", 8'h11);

    // R3/R4: top end
    for (int i = 0; i < 20; i++) step(1'b1);
    wt(PH);
    chk("R3", 8'h3F);
    step(1'b0); wt(PH);
    chk("R4", 8'h1F);
    step(1'b1); wt(PH);
    chk("R3", 8'h3F);

    // R3/R4: bottom end
    for (int i = 0; i < 40; i++) step(1'b0);
    wt(PH);
    chk("R3", 8'h40);
    step(1'b1); wt(PH);
    chk("R4", 8'h00);
    step(1'b0); wt(PH);
    chk("R4", 8'h40);

    // R5/R6 at bottom scale
    do_op(3'd2);
    chk("R5", 8'hC0);
    do_op(3'd0);
    chk("R6", 8'h40);

    // R1: reset mid-run
    rst_n = 1'b0; wt(2);
    chk("R1", 8'h10);
    rst_n = 1'b1; wt(PH);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule